// File: doc/BRIEF.md
# Quasi-Square-Wave H-Bridge Gate Sequencer

This block drives the four gates of a full H-bridge so that the bridge output is a low-frequency quasi-square wave whose conduction width can be varied. A phase generator splits each fundamental period into a positive and a negative half-cycle of equal length. A width generator produces one pulse at the start of every half-cycle, so it runs at twice the fundamental frequency. Each gate request is the AND of the active phase with that pulse. Because the same pulse train serves both halves, the positive and negative lobes always have the same width.

The bridge has two limbs. Limb one has upper switch A and lower switch B. Limb two has upper switch D and lower switch C. The positive-half request drives the diagonal pair A and C, and the negative-half request drives D and B. A dead-band stage in each limb stops a switch from turning on until its limb partner has been off for a set number of cycles. The duty word comes from a continuously resampled measurement. It is latched only when a half-cycle begins.

Top module: `qsw_hbridge_seq`

## Requirements
- R1: While `rst_n` is low, all four gate outputs are low. After release, the sequence starts at the beginning of the positive half-cycle, so no D/B pulse appears during the first HALF_CYC cycles.
- R2: HALF_CYC = CLK_HZ/(2*FUND_HZ), which is 1000 with the defaults. Gate A rises once per fundamental period, and successive rising edges are exactly 2*HALF_CYC cycles apart.
- R3: The pulse width in cycles is W = min(floor(duty*HALF_CYC/2^DUTY_W), MAX_CYC). A duty of zero produces no pulse on any gate.
- R4: MAX_CYC = HALF_CYC*MAX_PCT/100, which is 900 with the defaults. Any duty whose scaled value exceeds MAX_CYC gives exactly MAX_CYC.
- R5: In steady state, the negative-half pulse on D and B has the same width W as the positive-half pulse on A and C.
- R6: Gate C always equals gate A, and gate B always equals gate D.
- R7: A and B are never high together, D and C are never high together, and A and D are never high together.
- R8: The duty word is sampled only at the first clock edge of each half-cycle. Changing it during a pulse leaves that pulse's width unchanged, and the next half-cycle uses the new value.
- R9: Driving `en` low forces all four gates low in the same cycle, before the next clock edge. Raising it again restarts the sequence at the start of the positive half-cycle.
- R10: A switch turns on only after both switches of its limb have been off for DEAD_CYC counted cycles. After reset or enable, this makes the first positive pulse W-DEAD_CYC+1 cycles long (497 for duty 128 with DEAD_CYC=4), and every later pulse is W cycles long.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock at CLK_HZ |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Run enable; low forces gates off and restarts the sequence |
| duty | input | DUTY_W | Unsigned width request, latched at each half-cycle start |
| gate_a | output | 1 | Limb-one upper switch (positive half) |
| gate_b | output | 1 | Limb-one lower switch (negative half) |
| gate_c | output | 1 | Limb-two lower switch (positive half) |
| gate_d | output | 1 | Limb-two upper switch (negative half) |

## Verification
A duty change takes effect at the next half-cycle boundary, and each gate edge trails its raw request by one register in the dead-band stage. The sweep therefore waits two full periods after each duty change. It then counts high cycles over a window of exactly one period, which gives a width that does not depend on where the window starts. The first-pulse check after reset or enable counts from the first edge that sees the block running. The DEAD_CYC-1 extra delay then appears as a shorter high count in that first window. The test of `en` going low samples the outputs one time step after the drive and before any clock edge, because gating is combinational at the outputs.

// File: rtl/qsw_pkg.sv
// Shared types for the quasi-square-wave bridge sequencer.
// Assumes: a single clock domain; phase encoding is private to this block.
package qsw_pkg;
    typedef enum logic {
        PH_POS = 1'b0,
        PH_NEG = 1'b1
    } phase_e;
endpackage

// File: rtl/qsw_timebase.sv
// Half-cycle timebase: counts 0..HALF_CYC-1 within each half and toggles the
// phase at every wrap. Holds at the start of the positive half while idle.
// Assumes: HALF_CYC >= 2; the first running cycle is the positive half, count 0.
module qsw_timebase
    import qsw_pkg::*;
#(
    parameter int HALF_CYC = 1000,
    parameter int CNT_W    = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    output logic [CNT_W-1:0] cnt_o,
    output phase_e           phase_o,
    output logic             active_o,
    output logic             last_o
);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(HALF_CYC - 1);

    logic [CNT_W-1:0] cnt_q;
    phase_e           phase_q;
    logic             active_q;

    // Advance the in-half counter and flip the phase at the end of each half.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt_q    <= '0;
            phase_q  <= PH_POS;
            active_q <= 1'b0;
        end else if (!active_q) begin
            active_q <= 1'b1;
        end else if (cnt_q == LAST_CNT) begin
            cnt_q   <= '0;
            phase_q <= (phase_q == PH_POS) ? PH_NEG : PH_POS;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt_o    = cnt_q;
    assign phase_o  = phase_q;
    assign active_o = active_q;
    assign last_o   = active_q && (cnt_q == LAST_CNT);

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST_CNT);                                                   // R2
    AST_PHASE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        (en && last_o) |=> (phase_q != $past(phase_q)));                      // R2
    AST_IDLE_START: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (cnt_q == '0 && phase_q == PH_POS && !active_q));             // R9
endmodule

// File: rtl/qsw_width.sv
// Width generator: scales the duty word to a cycle count, clamps it, and
// latches it at each half-cycle start. It emits one raw request per phase.
// Assumes: duty may change in any cycle; only the latched copy is used.
module qsw_width
    import qsw_pkg::*;
#(
    parameter int DUTY_W   = 8,
    parameter int HALF_CYC = 1000,
    parameter int CNT_W    = 10,
    parameter int MAX_CYC  = 900
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DUTY_W-1:0] duty,
    input  logic [CNT_W-1:0]  cnt,
    input  phase_e            phase,
    input  logic              active,
    input  logic              last,
    output logic              raw_pos,
    output logic              raw_neg
);
    localparam int              PROD_W  = DUTY_W + CNT_W + 1;
    localparam logic [CNT_W-1:0] MAX_VAL = CNT_W'(MAX_CYC);

    logic [PROD_W-1:0] prod;
    logic [CNT_W-1:0]  scaled;
    logic [CNT_W-1:0]  target;
    logic [CNT_W-1:0]  width_q;
    logic              in_pulse;

    // Scale the duty word to cycles and clamp it to the maximum conduction width.
    always_comb begin
        prod   = PROD_W'(duty) * PROD_W'(HALF_CYC);
        scaled = CNT_W'(prod >> DUTY_W);
        target = (scaled > MAX_VAL) ? MAX_VAL : scaled;
    end

    // Capture the width only while idle or on the edge that opens a new half.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            width_q <= '0;
        end else if (!active || last) begin
            width_q <= target;
        end
    end

    // Edge-aligned pulse: high from the half start for width_q cycles.
    always_comb begin
        in_pulse = active && (cnt < width_q);
        raw_pos  = in_pulse && (phase == PH_POS);
        raw_neg  = in_pulse && (phase == PH_NEG);
    end

    AST_WIDTH_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
        width_q <= MAX_VAL);                                                  // R4
    AST_WIDTH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !last) |=> $stable(width_q));                              // R8
endmodule

// File: rtl/qsw_deadband.sv
// Limb dead-band stage: registers the upper and lower requests of one limb.
// A switch turns on only after both devices of the limb have been off for
// DEAD_CYC counted cycles. Turn-off follows the request one cycle later.
// Assumes: the counter restarts from zero on reset or when en is low.
module qsw_deadband #(
    parameter int DEAD_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic req_hi,
    input  logic req_lo,
    output logic gate_hi,
    output logic gate_lo
);
    localparam int              QW       = $clog2(DEAD_CYC + 1) + 1;
    localparam logic [QW-1:0]   DEAD_VAL = QW'(DEAD_CYC);

    logic          hi_q;
    logic          lo_q;
    logic [QW-1:0] quiet_q;
    logic          gap_ok;

    assign gap_ok = (quiet_q >= DEAD_VAL);

    // Register both gates, permitting a turn-on only after a full quiet gap.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            hi_q <= 1'b0;
            lo_q <= 1'b0;
        end else begin
            hi_q <= req_hi && !req_lo && !lo_q && (hi_q || gap_ok);
            lo_q <= req_lo && !req_hi && !hi_q && (lo_q || gap_ok);
        end
    end

    // Count consecutive cycles with the whole limb off, saturating at DEAD_CYC.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            quiet_q <= '0;
        end else if (hi_q || lo_q) begin
            quiet_q <= '0;
        end else if (!gap_ok) begin
            quiet_q <= quiet_q + 1'b1;
        end
    end

    assign gate_hi = hi_q;
    assign gate_lo = lo_q;

    AST_NO_SHOOT: assert property (@(posedge clk) disable iff (!rst_n)
        !(hi_q && lo_q));                                                     // R7
    AST_DEAD_HI: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hi_q) |-> $past(!lo_q && quiet_q >= DEAD_VAL));                 // R10
    AST_DEAD_LO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lo_q) |-> $past(!hi_q && quiet_q >= DEAD_VAL));                 // R10
endmodule

// File: rtl/qsw_hbridge_seq.sv
// Top of the quasi-square-wave H-bridge sequencer. It chains the timebase,
// the width generator and one dead-band stage per limb. Positive-half
// requests drive A (limb-one upper) and C (limb-two lower). Negative-half
// requests drive D (limb-two upper) and B (limb-one lower).
// Assumes: CLK_HZ is a multiple of 2*FUND_HZ; en gates the outputs directly.
module qsw_hbridge_seq
    import qsw_pkg::*;
#(
    parameter int CLK_HZ   = 100_000,
    parameter int FUND_HZ  = 50,
    parameter int DUTY_W   = 8,
    parameter int MAX_PCT  = 90,
    parameter int DEAD_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [DUTY_W-1:0] duty,
    output logic              gate_a,
    output logic              gate_b,
    output logic              gate_c,
    output logic              gate_d
);
    localparam int HALF_CYC = CLK_HZ / (2 * FUND_HZ);
    localparam int CNT_W    = $clog2(HALF_CYC);
    localparam int MAX_CYC  = HALF_CYC * MAX_PCT / 100;
    localparam int N_LIMB   = 2;

    logic [CNT_W-1:0]  cnt;
    phase_e            phase;
    logic              active;
    logic              last;
    logic              raw_pos;
    logic              raw_neg;
    logic [N_LIMB-1:0] g_hi;
    logic [N_LIMB-1:0] g_lo;

    qsw_timebase #(
        .HALF_CYC (HALF_CYC),
        .CNT_W    (CNT_W)
    ) u_timebase (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .cnt_o    (cnt),
        .phase_o  (phase),
        .active_o (active),
        .last_o   (last)
    );

    qsw_width #(
        .DUTY_W   (DUTY_W),
        .HALF_CYC (HALF_CYC),
        .CNT_W    (CNT_W),
        .MAX_CYC  (MAX_CYC)
    ) u_width (
        .clk     (clk),
        .rst_n   (rst_n),
        .duty    (duty),
        .cnt     (cnt),
        .phase   (phase),
        .active  (active),
        .last    (last),
        .raw_pos (raw_pos),
        .raw_neg (raw_neg)
    );

    // One dead-band stage per limb: limb 0 upper is positive, limb 1 upper is negative.
    for (genvar l = 0; l < N_LIMB; l++) begin : g_limb
        logic up_req;
        logic dn_req;
        assign up_req = (l == 0) ? raw_pos : raw_neg;
        assign dn_req = (l == 0) ? raw_neg : raw_pos;
        qsw_deadband #(
            .DEAD_CYC (DEAD_CYC)
        ) u_dead (
            .clk     (clk),
            .rst_n   (rst_n),
            .en      (en),
            .req_hi  (up_req),
            .req_lo  (dn_req),
            .gate_hi (g_hi[l]),
            .gate_lo (g_lo[l])
        );
    end

    // Gate the registered drives with en so a disable takes effect at once.
    always_comb begin
        gate_a = g_hi[0] && en;
        gate_b = g_lo[0] && en;
        gate_d = g_hi[1] && en;
        gate_c = g_lo[1] && en;
    end

    AST_OUT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !(gate_a || gate_b || gate_c || gate_d));                     // R9
    AST_HALF_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_a && gate_d));                                                 // R7
    AST_RST_QUIET: assert property (@(posedge clk)
        !rst_n |=> !(gate_a || gate_b || gate_c || gate_d));                  // R1
endmodule

// File: tb/test_qsw_hbridge_seq.sv
// Self-checking bench: a duty sweep from a vector table, then directed tests
// for reset, period, mid-pulse duty change, enable and dead band.
module test_qsw_hbridge_seq;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 1000;
    localparam int PERIOD     = 2 * HALF;
    localparam int DEAD       = 4;
    localparam int NVEC       = 8;
    localparam int VEC_DUTY [NVEC] = '{0, 1, 64, 128, 200, 230, 231, 255};
    localparam int VEC_W    [NVEC] = '{0, 3, 250, 500, 781, 898, 900, 900};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b1;
    logic [7:0] duty = 8'd128;
    logic       gate_a, gate_b, gate_c, gate_d;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit done  = 1'b0;

    qsw_hbridge_seq #(.CLK_HZ(100_000), .FUND_HZ(50), .DUTY_W(8),
                      .MAX_PCT(90), .DEAD_CYC(DEAD)) i_qsw_hbridge_seq (
        .clk(clk), .rst_n(rst_n), .en(en), .duty(duty),
        .gate_a(gate_a), .gate_b(gate_b), .gate_c(gate_c), .gate_d(gate_d)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Watchdog: a hung run is counted as a failure and still summarised.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !done) begin
            n_chk = n_chk + 1;
            n_bad = n_bad + 1;
            $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp_v);
        n_chk = n_chk + 1;
        if (act != exp_v) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
        end
    endtask

    // Sample n negedges and tally gate activity.
    task automatic window(input int n, output int a_hi, output int d_hi,
                          output int a_rise, output int pair_err, output int excl_err);
        logic prev_a;
        a_hi = 0; d_hi = 0; a_rise = 0; pair_err = 0; excl_err = 0;
        prev_a = gate_a;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (gate_a) a_hi++;
            if (gate_d) d_hi++;
            if (gate_a && !prev_a) a_rise++;
            if (gate_c != gate_a || gate_b != gate_d) pair_err++;
            if ((gate_a && gate_b) || (gate_d && gate_c) || (gate_a && gate_d)) excl_err++;
            prev_a = gate_a;
        end
    endtask

    task automatic wait_a_rise();
        logic prev_a;
        @(negedge clk);
        prev_a = gate_a;
        forever begin
            @(negedge clk);
            if (gate_a && !prev_a) break;
            prev_a = gate_a;
        end
    endtask

    initial begin
        int a_hi, d_hi, a_rise, pe, xe, gap, cnt_a;

        // R1: reset state.
        repeat (5) @(negedge clk);
        check("R1 reset gates", {28'd0, gate_a, gate_b, gate_c, gate_d}, 0);
        rst_n = 1'b1;
        window(HALF, a_hi, d_hi, a_rise, pe, xe);
        check("R1 first half positive (D quiet)", d_hi, 0);
        check("R10 first pulse after reset", a_hi, 500 - DEAD + 1);
        window(HALF, a_hi, d_hi, a_rise, pe, xe);
        check("R5 first negative pulse", d_hi, 500);

        // Vector sweep: R3/R4/R5/R6/R7/R2.
        for (int v = 0; v < NVEC; v++) begin
            duty = VEC_DUTY[v][7:0];
            repeat (2 * PERIOD) @(negedge clk);
            window(PERIOD, a_hi, d_hi, a_rise, pe, xe);
            check((VEC_W[v] == 900) ? "R4 clamp width A" : "R3 width A", a_hi, VEC_W[v]);
            check("R5 width D equals A", d_hi, VEC_W[v]);
            check("R2 one A pulse per period", a_rise, (VEC_W[v] > 0) ? 1 : 0);
            check("R6 C==A and B==D", pe, 0);
            check("R7 no overlap", xe, 0);
        end

        // R2: rising-edge spacing.
        duty = 8'd128;
        repeat (2 * PERIOD) @(negedge clk);
        wait_a_rise();
        gap = 0;
        begin
            logic prev_a;
            prev_a = gate_a;
            forever begin
                @(negedge clk);
                gap++;
                if (gate_a && !prev_a) break;
                prev_a = gate_a;
            end
        end
        check("R2 A rise spacing", gap, PERIOD);

        // R8: duty change during a pulse does not alter it.
        wait_a_rise();
        cnt_a = 1;
        duty = 8'd255;
        forever begin
            @(negedge clk);
            if (!gate_a) break;
            cnt_a++;
        end
        check("R8 pulse unchanged by mid-pulse duty", cnt_a, 500);
        window(PERIOD - 600, a_hi, d_hi, a_rise, pe, xe);
        check("R8 next half uses new duty", d_hi, 900);

        // R9: enable low forces outputs low in the same cycle.
        duty = 8'd128;
        repeat (2 * PERIOD) @(negedge clk);
        wait_a_rise();
        repeat (10) @(negedge clk);
        en = 1'b0;
        #1;
        check("R9 gates low at once", {28'd0, gate_a, gate_b, gate_c, gate_d}, 0);
        repeat (20) @(negedge clk);
        check("R9 gates stay low", {28'd0, gate_a, gate_b, gate_c, gate_d}, 0);
        en = 1'b1;
        window(HALF, a_hi, d_hi, a_rise, pe, xe);
        check("R9 restart in positive half", d_hi, 0);
        check("R10 first pulse after enable", a_hi, 500 - DEAD + 1);
        window(HALF, a_hi, d_hi, a_rise, pe, xe);
        check("R9 negative half follows", d_hi, 500);
        check("R9 A quiet in negative half", a_hi, 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule